// File: doc/BRIEF.md
# Inter-Core Doorbell Message Dispatcher

This block turns doorbell messages issued by any core of a multi-core cluster into per-core pending interrupt flags. A message is a 32-bit word carrying a message type, a broadcast flag and a processor ID tag. Two types are honoured: a normal doorbell and a critical doorbell, each owning its own pending flag in every core. All other type codes, including the three guest doorbell variants, are dropped without any effect.

A send operation raises the flag selected by the type in every targeted core and gives each of them a one-cycle interrupt-notify pulse. A core is targeted when the broadcast flag is set or when its own ID register equals the message tag. A clear operation lowers the selected flag in the issuing core only. Flags also drop when the interrupt controller acknowledges that a core has taken the interrupt. Delivering the interrupt to the core is outside this block.

Top module: `doorbell_dispatch`

## Requirements
- R1: After reset every pending flag and every notify pulse output is low.
- R2: A send of type code 0 (normal doorbell) raises db_pend_o of each targeted core at the first clock edge after msg_valid_i is sampled high.
- R3: A send of type code 1 (critical doorbell) raises crit_pend_o of each targeted core at the same edge, leaving db_pend_o untouched.
- R4: On a send, message bit 26 set targets every core; when it is clear, exactly the cores whose ID register equals message bits [13:0] are targeted. Bits [25:14] carry no meaning.
- R5: Each core targeted by a send of code 0 or 1 shows a one-cycle high on irq_notify_o in the cycle after the message; untargeted cores and clear operations give no pulse.
- R6: Type codes 2, 3 and 4 (guest doorbell, guest critical doorbell, guest machine-check doorbell) and codes 5 to 31 change no pending flag and give no pulse, for both send and clear.
- R7: A clear (msg_op_i = 1) of code 0 or 1 lowers only the selected flag of core src_core_i; the broadcast flag and tag are ignored and every other flag is kept.
- R8: A high on take_db_i[i] or take_crit_i[i] lowers the matching flag of core i at the next edge.
- R9: When a send raises a flag in the same cycle as a take-acknowledge lowers it, the flag ends high.
- R10: A flag that is neither set nor cleared keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| msg_valid_i | input | 1 | Message strobe, one message per high cycle |
| msg_op_i | input | 1 | 0 = send, 1 = clear |
| msg_word_i | input | 32 | Type [31:27], broadcast [26], ID tag [13:0] |
| src_core_i | input | $clog2(NUM_CORES) | Index of the issuing core |
| core_id_i | input | NUM_CORES*ID_W | Per-core processor ID, core i in slice i |
| take_db_i | input | NUM_CORES | Per-core normal doorbell taken acknowledge |
| take_crit_i | input | NUM_CORES | Per-core critical doorbell taken acknowledge |
| db_pend_o | output | NUM_CORES | Per-core normal doorbell pending |
| crit_pend_o | output | NUM_CORES | Per-core critical doorbell pending |
| irq_notify_o | output | NUM_CORES | Per-core one-cycle notify pulse |

## Verification
A send raising a flag and a take-acknowledge lowering the same flag can land in one cycle. The bench provokes this by driving a broadcast or tagged send together with acknowledges on targeted and untargeted cores, and judges the result at the next sample: targeted cores must hold the flag high while acknowledged untargeted cores must drop it. Around this, a sweep over all 32 type codes, both operations, both broadcast settings, several tags (including a tag shared by two cores and one matching none) and every issuing core is compared against a bench model.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int MSG_W     = 32;
  localparam int TYPE_HI   = 31;
  localparam int TYPE_LO   = 27;
  localparam int BCAST_BIT = 26;

  localparam logic [4:0] MT_DB    = 5'd0;
  localparam logic [4:0] MT_CRIT  = 5'd1;
  localparam logic [4:0] MT_GDB   = 5'd2;
  localparam logic [4:0] MT_GCRIT = 5'd3;
  localparam logic [4:0] MT_GMC   = 5'd4;

  typedef enum logic {OP_SEND = 1'b0, OP_CLEAR = 1'b1} msg_op_e;

  typedef struct packed {
    logic db;
    logic crit;
  } db_class_t;
endpackage

// File: rtl/db_decode.sv
module db_decode import db_pkg::*; #(
  parameter int ID_W = 14
) (
  input  logic [MSG_W-1:0] msg_word_i,
  output db_class_t        class_o,
  output logic             bcast_o,
  output logic [ID_W-1:0]  tag_o
);
  logic [TYPE_HI-TYPE_LO:0] mtype;

  assign mtype   = msg_word_i[TYPE_HI:TYPE_LO];
  assign bcast_o = msg_word_i[BCAST_BIT];
  assign tag_o   = msg_word_i[ID_W-1:0];

  always_comb begin
    class_o = '0;
    case (mtype)
      MT_DB:   class_o.db   = 1'b1;
      MT_CRIT: class_o.crit = 1'b1;
      // guest variants and unknown codes: no action
      MT_GDB, MT_GCRIT, MT_GMC: class_o = '0;
      default: class_o = '0;
    endcase
  end
endmodule

// File: rtl/db_target.sv
module db_target import db_pkg::*; #(
  parameter int NUM_CORES = 4,
  parameter int ID_W      = 14,
  localparam int IDX_W    = $clog2(NUM_CORES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic                      op_i,
  input  db_class_t                 class_i,
  input  logic                      bcast_i,
  input  logic [ID_W-1:0]           tag_i,
  input  logic [IDX_W-1:0]          src_core_i,
  input  logic [NUM_CORES*ID_W-1:0] core_id_i,
  output logic [NUM_CORES-1:0]      set_db_o,
  output logic [NUM_CORES-1:0]      set_crit_o,
  output logic [NUM_CORES-1:0]      clr_db_o,
  output logic [NUM_CORES-1:0]      clr_crit_o
);
  logic is_send, is_clear;
  assign is_send  = valid_i && (op_i == OP_SEND);
  assign is_clear = valid_i && (op_i == OP_CLEAR);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic hit, local_core;
    assign hit        = bcast_i || (core_id_i[i*ID_W +: ID_W] == tag_i);
    assign local_core = (src_core_i == IDX_W'(i));
    assign set_db_o[i]   = is_send  && hit && class_i.db;
    assign set_crit_o[i] = is_send  && hit && class_i.crit;
    assign clr_db_o[i]   = is_clear && local_core && class_i.db;
    assign clr_crit_o[i] = is_clear && local_core && class_i.crit;
  end

  // R7: a clear touches at most one core
  a_r7_clear_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_db_o | clr_crit_o));
  // R7: a clear never sets
  a_r7_clear_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_db_o | clr_crit_o) != '0) |-> ((set_db_o | set_crit_o) == '0));
endmodule

// File: rtl/db_pend_cell.sv
module db_pend_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_db_i,
  input  logic set_crit_i,
  input  logic clr_db_i,
  input  logic clr_crit_i,
  input  logic take_db_i,
  input  logic take_crit_i,
  output logic db_q_o,
  output logic crit_q_o,
  output logic notify_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_q_o   <= 1'b0;
      crit_q_o <= 1'b0;
      notify_o <= 1'b0;
    end else begin
      // set has priority over any clear source
      if (set_db_i)                   db_q_o <= 1'b1;
      else if (clr_db_i || take_db_i) db_q_o <= 1'b0;
      if (set_crit_i)                     crit_q_o <= 1'b1;
      else if (clr_crit_i || take_crit_i) crit_q_o <= 1'b0;
      notify_o <= set_db_i || set_crit_i;
    end
  end

  a_r9_set_wins_db: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_db_i |=> db_q_o);
  a_r9_set_wins_crit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_crit_i |=> crit_q_o);
  a_r8_take_clears_db: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_db_i && !set_db_i) |=> !db_q_o);
  a_r8_take_clears_crit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_crit_i && !set_crit_i) |=> !crit_q_o);
  a_r10_hold_db: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_db_i && !clr_db_i && !take_db_i) |=> $stable(db_q_o));
  a_r10_hold_crit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_crit_i && !clr_crit_i && !take_crit_i) |=> $stable(crit_q_o));
endmodule

// File: rtl/doorbell_dispatch.sv
module doorbell_dispatch import db_pkg::*; #(
  parameter int NUM_CORES = 4,
  parameter int ID_W      = 14,
  localparam int IDX_W    = $clog2(NUM_CORES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      msg_valid_i,
  input  logic                      msg_op_i,
  input  logic [MSG_W-1:0]          msg_word_i,
  input  logic [IDX_W-1:0]          src_core_i,
  input  logic [NUM_CORES*ID_W-1:0] core_id_i,
  input  logic [NUM_CORES-1:0]      take_db_i,
  input  logic [NUM_CORES-1:0]      take_crit_i,
  output logic [NUM_CORES-1:0]      db_pend_o,
  output logic [NUM_CORES-1:0]      crit_pend_o,
  output logic [NUM_CORES-1:0]      irq_notify_o
);
  db_class_t              msg_class;
  logic                   msg_bcast;
  logic [ID_W-1:0]        msg_tag;
  logic [NUM_CORES-1:0]   set_db, set_crit, clr_db, clr_crit;

  db_decode #(.ID_W(ID_W)) u_decode (
    .msg_word_i (msg_word_i),
    .class_o    (msg_class),
    .bcast_o    (msg_bcast),
    .tag_o      (msg_tag)
  );

  db_target #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) u_target (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (msg_valid_i),
    .op_i       (msg_op_i),
    .class_i    (msg_class),
    .bcast_i    (msg_bcast),
    .tag_i      (msg_tag),
    .src_core_i (src_core_i),
    .core_id_i  (core_id_i),
    .set_db_o   (set_db),
    .set_crit_o (set_crit),
    .clr_db_o   (clr_db),
    .clr_crit_o (clr_crit)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_cell
    db_pend_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .set_db_i    (set_db[i]),
      .set_crit_i  (set_crit[i]),
      .clr_db_i    (clr_db[i]),
      .clr_crit_i  (clr_crit[i]),
      .take_db_i   (take_db_i[i]),
      .take_crit_i (take_crit_i[i]),
      .db_q_o      (db_pend_o[i]),
      .crit_q_o    (crit_pend_o[i]),
      .notify_o    (irq_notify_o[i])
    );
  end

  // R5: a notify always comes with a raised flag
  a_r5_notify_has_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_notify_o & ~(db_pend_o | crit_pend_o)) == '0);
  // R5: clear operations never notify
  a_r5_clear_no_notify: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && msg_op_i) |=> (irq_notify_o == '0));
  // R6: a message with a code above 1 changes no flag
  a_r6_ignored_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && msg_word_i[TYPE_HI:TYPE_LO] > 5'd1 &&
     take_db_i == '0 && take_crit_i == '0)
    |=> ($stable(db_pend_o) && $stable(crit_pend_o) && irq_notify_o == '0));
endmodule

// File: tb/doorbell_dispatch_tb.sv
`timescale 1ns/1ps
module doorbell_dispatch_tb;
  localparam int N    = 4;
  localparam int ID_W = 14;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            msg_valid = 1'b0;
  logic            msg_op = 1'b0;
  logic [31:0]     msg_word = '0;
  logic [1:0]      src_core = '0;
  logic [N*ID_W-1:0] core_id;
  logic [N-1:0]    take_db = '0, take_crit = '0;
  logic [N-1:0]    db_pend, crit_pend, irq_notify;

  logic [N-1:0]    exp_db = '0, exp_crit = '0, exp_nt = '0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [ID_W-1:0] ids [N];
  logic [ID_W-1:0] tags [5];

  always #10 clk = ~clk;

  doorbell_dispatch #(.NUM_CORES(N), .ID_W(ID_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .msg_valid_i(msg_valid), .msg_op_i(msg_op),
    .msg_word_i(msg_word), .src_core_i(src_core), .core_id_i(core_id),
    .take_db_i(take_db), .take_crit_i(take_crit),
    .db_pend_o(db_pend), .crit_pend_o(crit_pend), .irq_notify_o(irq_notify)
  );

  task automatic check(string req);
    checks++;
    if (db_pend !== exp_db || crit_pend !== exp_crit || irq_notify !== exp_nt) begin
      failures++;
      $display("FAIL %s db=%b/%b crit=%b/%b notify=%b/%b (actual/expected)",
               req, db_pend, exp_db, crit_pend, exp_crit, irq_notify, exp_nt);
    end
  endtask

  // drive one message with optional acknowledges, update model, check
  task automatic msg(input logic [4:0] t, input logic op, input logic bc,
                     input logic [ID_W-1:0] tag, input logic [1:0] src,
                     input logic [N-1:0] tdb, input logic [N-1:0] tcr,
                     input string req);
    logic [N-1:0] sdb, scr;
    @(negedge clk);
    msg_valid = 1'b1; msg_op = op; src_core = src;
    msg_word  = {t, bc, 12'hA5A, tag};
    take_db = tdb; take_crit = tcr;
    sdb = '0; scr = '0; exp_nt = '0;
    for (int i = 0; i < N; i++) begin
      logic tg;
      tg = bc || (ids[i] == tag);
      if (op == 1'b0 && tg && t == 5'd0) sdb[i] = 1'b1;
      if (op == 1'b0 && tg && t == 5'd1) scr[i] = 1'b1;
    end
    exp_nt = sdb | scr;
    exp_db = exp_db & ~tdb; exp_crit = exp_crit & ~tcr;
    if (op == 1'b1 && t == 5'd0) exp_db[src]   = 1'b0;
    if (op == 1'b1 && t == 5'd1) exp_crit[src] = 1'b0;
    exp_db = exp_db | sdb; exp_crit = exp_crit | scr;
    @(negedge clk);
    msg_valid = 1'b0; take_db = '0; take_crit = '0;
    check(req);
  endtask

  initial begin
    ids[0] = 14'h0105; ids[1] = 14'h3FFF; ids[2] = 14'h0105; ids[3] = 14'h0002;
    for (int i = 0; i < N; i++) core_id[i*ID_W +: ID_W] = ids[i];
    tags[0] = 14'h0105; tags[1] = 14'h3FFF; tags[2] = 14'h0002;
    tags[3] = 14'h0000; tags[4] = 14'h1105;

    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // R2 R3 R4: tagged sends, shared tag hits cores 0 and 2
    msg(5'd0, 1'b0, 1'b0, 14'h0105, 2'd1, '0, '0, "R2 R4 tagged db shared id");
    msg(5'd1, 1'b0, 1'b0, 14'h0002, 2'd0, '0, '0, "R3 R4 tagged crit");
    msg(5'd1, 1'b0, 1'b0, 14'h0000, 2'd0, '0, '0, "R4 R5 no match");
    // R10: idle cycle keeps flags, pulse gone
    @(negedge clk); exp_nt = '0; check("R10 R5 hold and pulse end");

    // R8: acknowledges alone
    msg(5'd7, 1'b0, 1'b1, 14'h0, 2'd0, 4'b0001, 4'b1000, "R8 take clears");
    // R9: broadcast send with acks on all cores
    msg(5'd0, 1'b0, 1'b1, 14'h0, 2'd0, 4'b1111, 4'b0000, "R9 set wins over take");
    // R9: tagged crit to core 3 with acks on cores 2 and 3
    msg(5'd1, 1'b0, 1'b0, 14'h0002, 2'd0, 4'b0000, 4'b1100, "R9 R8 mixed set and take");

    // sweep: R2..R7 over all types, ops, broadcast, tags and issuing cores
    for (int t = 0; t < 32; t++)
      for (int op = 0; op < 2; op++)
        for (int bc = 0; bc < 2; bc++)
          for (int k = 0; k < 5; k++)
            for (int s = 0; s < N; s++) begin
              if (op == 1) begin
                msg(5'd0, 1'b0, 1'b1, 14'h0, 2'(s), '0, '0, "R2 R4 broadcast fill");
                msg(5'd1, 1'b0, 1'b1, 14'h0, 2'(s), '0, '0, "R3 R4 broadcast fill");
              end else if (t > 1) begin
                msg(5'd0, 1'b0, 1'b1, 14'h0, 2'(s), '0, '0, "R2 broadcast fill");
              end
              msg(5'(t), 1'(op), 1'(bc), tags[k], 2'(s), '0, '0,
                  (t > 1) ? "R6 ignored type" :
                  (op == 1) ? "R7 local clear" : "R2 R3 R4 R5 sweep send");
              if (op == 1) begin
                msg(5'd3, 1'b0, 1'b0, 14'h3FFF, 2'(s), '0, '0, "R7 R10 post clear");
              end
            end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule